// File: doc/BRIEF.md
# Audio Frame Fetch Sequencer

This block drives the memory reads for a sample playback path. Software programs the start address and the exclusive end address of a frame of 16-bit words, then writes a control code that plays the frame once or loops it until stopped. The engine reads one word at a time through a request/acknowledge memory port. Each word goes out to a downstream sample buffer over a valid/ready handshake, and the read address advances by two on every acknowledged read.

The start and end registers are double buffered. A CPU write lands in a holding copy, and the engine copies the holding values into its working state only when it starts a frame, either from idle or at a loop boundary. A new frame can therefore be queued while the current one plays. The `play_active` line is high while a frame is being fetched. At each loop boundary it drops for exactly one cycle, so an external edge counter can count repetitions.

Top module: `snd_frame_fetch`

## Requirements
- R1: After reset the control code reads 00, `play_active`, `mem_req` and `smp_valid` are low, and the current-address register (select 3) reads 0.
- R2: A control write (select 0) with bit 0 clear stores 00 (this includes 10). 01 stores play-once and 11 stores loop. The code reads back in bits 1:0 of select 0.
- R3: When the engine is idle and the stored code is nonzero, `play_active` rises one cycle after the control register takes the code, provided the held start and end addresses differ. The first read is at the held start address.
- R4: Reads in a frame go to start, start+2, and so on up to end-2. Each word is delivered unchanged and in order. A word offered with `smp_ready` low stays valid and stable.
- R5: Select 3 reads the address of the next read. During playback it is even and lies between start and end inclusive.
- R6: In play-once mode, after the acknowledge of the last word `play_active` is low in the next cycle, the control code reads 00, and select 3 reads the end address.
- R7: In loop mode `play_active` is low for exactly one cycle at each frame boundary. Reading then resumes at the held start address.
- R8: Start/end writes made during playback do not alter the frame in progress. They take effect at the next frame start.
- R9: When the control register becomes 00, `play_active` and `mem_req` are low one cycle later and no further reads are issued.
- R10: Start (select 1) and end (select 2) writes store the value with bit 0 cleared. Reads of selects 1 and 2 return the held values.
- R11: A frame whose held start equals its held end issues no reads, and `play_active` stays low.
- R12: A new read request is raised only if, in the previous cycle, `smp_ready` was high and no word was waiting. Once raised, the request is held until acknowledged unless playback is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 start, 2 end, 3 current address |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Register read data for the selected register |
| mem_req | output | 1 | Word read request |
| mem_addr | output | AW | Byte address of the requested word |
| mem_ack | input | 1 | Read acknowledge; data is valid in the same cycle |
| mem_rdata | input | DW | Read data |
| smp_valid | output | 1 | Word available to the sample buffer |
| smp_data | output | DW | Word to the sample buffer |
| smp_ready | input | 1 | Sample buffer can accept a word |
| play_active | output | 1 | A frame is being fetched |

## Verification
The hardest case to reach is a queued frame that replaces the looping frame exactly at the boundary. It needs a holding-register write while a long frame is mid-play, followed by random memory latency and random back-pressure around the wrap. The stimulus starts a long looping frame and waits until two words have been delivered before it queues a short frame. A scoreboard that follows the exclusive end address then checks that the long frame finishes intact and that the short one repeats. Every loop boundary is also checked for a low pulse of exactly one cycle.

// File: rtl/snd_fetch_pkg.sv
package snd_fetch_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_BASE = 2'd1,
        SEL_END  = 2'd2,
        SEL_CUR  = 2'd3
    } reg_sel_e;

    localparam logic [1:0] CTRL_OFF  = 2'b00;
    localparam logic [1:0] CTRL_ONCE = 2'b01;
    localparam logic [1:0] CTRL_LOOP = 2'b11;

endpackage

// File: rtl/snd_fetch_regs.sv
module snd_fetch_regs
    import snd_fetch_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    sel,
    input  logic [AW-1:0] wdata,
    output logic [AW-1:0] rdata,
    input  logic [AW-1:0] cur_i,
    input  logic          once_done_i,
    output logic [1:0]    ctrl_o,
    output logic [AW-1:0] base_h_o,
    output logic [AW-1:0] end_h_o
);

    typedef struct packed {
        logic [1:0]    ctrl;
        logic [AW-1:0] base;
        logic [AW-1:0] fin;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (once_done_i) r_d.ctrl = CTRL_OFF;
        if (wr_en) begin
            case (reg_sel_e'(sel))
                SEL_CTRL: r_d.ctrl = wdata[0] ? {wdata[1], 1'b1} : CTRL_OFF;
                SEL_BASE: r_d.base = {wdata[AW-1:1], 1'b0};
                SEL_END:  r_d.fin  = {wdata[AW-1:1], 1'b0};
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (reg_sel_e'(sel))
            SEL_CTRL: rdata = {{(AW-2){1'b0}}, r_q.ctrl};
            SEL_BASE: rdata = r_q.base;
            SEL_END:  rdata = r_q.fin;
            default:  rdata = cur_i;
        endcase
    end

    assign ctrl_o   = r_q.ctrl;
    assign base_h_o = r_q.base;
    assign end_h_o  = r_q.fin;

    // R2
    ctrl_off_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == 2'd0 && !wdata[0]) |=> (ctrl_o == CTRL_OFF));

    // R6
    once_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (once_done_i && !wr_en) |=> (ctrl_o == CTRL_OFF));

endmodule

// File: rtl/snd_fetch_engine.sv
module snd_fetch_engine #(
    parameter int AW = 24,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    ctrl_i,
    input  logic [AW-1:0] base_h_i,
    input  logic [AW-1:0] end_h_i,
    output logic          mem_req_o,
    output logic [AW-1:0] mem_addr_o,
    input  logic          mem_ack_i,
    input  logic [DW-1:0] mem_rdata_i,
    output logic          smp_valid_o,
    output logic [DW-1:0] smp_data_o,
    input  logic          smp_ready_i,
    output logic          active_o,
    output logic [AW-1:0] cur_o,
    output logic          once_done_o
);

    localparam logic [AW-1:0] STEP = AW'(DW / 8);

    typedef struct packed {
        logic          active;
        logic          req;
        logic          vld;
        logic [DW-1:0] dat;
        logic [AW-1:0] cur;
        logic [AW-1:0] fin;
    } eng_t;

    eng_t e_d, e_q;
    logic          frame_done;
    logic [AW-1:0] nxt_addr;

    assign nxt_addr = e_q.cur + STEP;

    always_comb begin
        e_d        = e_q;
        frame_done = 1'b0;
        if (e_q.vld && smp_ready_i) e_d.vld = 1'b0;
        if (!ctrl_i[0]) begin
            e_d.active = 1'b0;
            e_d.req    = 1'b0;
        end else if (!e_q.active) begin
            if (base_h_i != end_h_i) begin
                e_d.active = 1'b1;
                e_d.cur    = base_h_i;
                e_d.fin    = end_h_i;
            end
        end else if (e_q.req) begin
            if (mem_ack_i) begin
                e_d.req = 1'b0;
                e_d.vld = 1'b1;
                e_d.dat = mem_rdata_i;
                e_d.cur = nxt_addr;
                if (nxt_addr == e_q.fin) begin
                    e_d.active = 1'b0;
                    frame_done = 1'b1;
                end
            end
        end else if (!e_q.vld && smp_ready_i) begin
            e_d.req = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign mem_req_o   = e_q.req;
    assign mem_addr_o  = e_q.cur;
    assign smp_valid_o = e_q.vld;
    assign smp_data_o  = e_q.dat;
    assign active_o    = e_q.active;
    assign cur_o       = e_q.cur;
    assign once_done_o = frame_done && !ctrl_i[1];

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i && ctrl_i[0]) |=> mem_req_o);

    // R12
    req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_o) |-> ($past(smp_ready_i) && !$past(smp_valid_o)));

    // R4
    out_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid_o && !smp_ready_i) |=> (smp_valid_o && $stable(smp_data_o)));

    // R5
    addr_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (mem_addr_o[0] == 1'b0));

    // R9
    stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_i[0] |=> (!active_o && !mem_req_o));

    // R7
    loop_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(active_o) && ctrl_i == 2'b11 && base_h_i != end_h_i) |=> active_o);

endmodule

// File: rtl/snd_frame_fetch.sv
module snd_frame_fetch #(
    parameter int AW = 24,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_sel,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] reg_rdata,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    output logic          smp_valid,
    output logic [DW-1:0] smp_data,
    input  logic          smp_ready,
    output logic          play_active
);

    logic [1:0]    ctrl;
    logic [AW-1:0] base_h;
    logic [AW-1:0] end_h;
    logic [AW-1:0] cur;
    logic          once_done;

    snd_fetch_regs #(.AW(AW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_wr),
        .sel         (reg_sel),
        .wdata       (reg_wdata),
        .rdata       (reg_rdata),
        .cur_i       (cur),
        .once_done_i (once_done),
        .ctrl_o      (ctrl),
        .base_h_o    (base_h),
        .end_h_o     (end_h)
    );

    snd_fetch_engine #(.AW(AW), .DW(DW)) u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_i      (ctrl),
        .base_h_i    (base_h),
        .end_h_i     (end_h),
        .mem_req_o   (mem_req),
        .mem_addr_o  (mem_addr),
        .mem_ack_i   (mem_ack),
        .mem_rdata_i (mem_rdata),
        .smp_valid_o (smp_valid),
        .smp_data_o  (smp_data),
        .smp_ready_i (smp_ready),
        .active_o    (play_active),
        .cur_o       (cur),
        .once_done_o (once_done)
    );

endmodule

// File: tb/tb_snd_frame_fetch.sv
`timescale 1ns/1ps
module tb_snd_frame_fetch;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [23:0] reg_wdata = '0;
    logic [23:0] reg_rdata;
    logic        mem_req;
    logic [23:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        smp_valid;
    logic [15:0] smp_data;
    logic        smp_ready = 1'b1;
    logic        play_active;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    bit rnd_ready = 0;
    bit loop_mon = 0;

    logic [23:0] exp_addr, exp_end, nb, ne;
    int wcnt = 0;

    always #10 clk = ~clk;

    snd_frame_fetch dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .smp_valid(smp_valid), .smp_data(smp_data), .smp_ready(smp_ready),
        .play_active(play_active)
    );

    function automatic logic [15:0] fdat(input logic [23:0] a);
        return a[16:1] ^ a[23:8] ^ 16'h3C5A;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // memory model: random latency, one-cycle acknowledge
    initial begin
        int lat;
        lat = 0;
        forever begin
            @(posedge clk);
            #1;
            if (mem_ack) begin
                mem_ack = 1'b0;
                lat = $urandom % 4;
            end else if (mem_req) begin
                if (lat == 0) begin
                    mem_ack   = 1'b1;
                    mem_rdata = fdat(mem_addr);
                end else lat--;
            end
        end
    end

    // downstream ready driver
    initial begin
        forever begin
            @(posedge clk);
            #2;
            smp_ready = rnd_ready ? (($urandom % 4) != 0) : 1'b1;
        end
    end

    // monitor and scoreboard
    logic pv = 0, pr = 0, preq = 0, pa = 0;
    logic [15:0] pd = 0;
    int lowrun = 0;
    bit seen_fall = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (smp_valid && smp_ready) begin
                chk(smp_data == fdat(exp_addr), "R4 R8 word", smp_data, fdat(exp_addr));
                wcnt++;
                exp_addr = exp_addr + 24'd2;
                if (exp_addr == exp_end) begin
                    exp_addr = nb;
                    exp_end  = ne;
                end
            end
            if (pv && !pr)
                chk(smp_valid && smp_data == pd, "R4 hold", {smp_valid, smp_data}, {1'b1, pd});
            if (mem_req && !preq)
                chk(pr && !pv, "R12 gate", {pr, pv}, 2'b10);
            if (loop_mon) begin
                if (pa && !play_active) begin
                    seen_fall = 1;
                    lowrun = 0;
                end
                if (!play_active) lowrun++;
                else if (seen_fall) begin
                    chk(lowrun == 1, "R7 gap", lowrun, 1);
                    seen_fall = 0;
                end
            end else begin
                seen_fall = 0;
                lowrun = 0;
            end
            pv = smp_valid; pr = smp_ready; pd = smp_data; preq = mem_req; pa = play_active;
        end
    end

    task automatic wr(input logic [1:0] s, input logic [23:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [23:0] v);
        @(negedge clk);
        reg_sel = s;
        #1 v = reg_rdata;
    endtask

    task automatic sb_set(input logic [23:0] b, input logic [23:0] e);
        exp_addr = b; exp_end = e; nb = b; ne = e; wcnt = 0;
    endtask

    task automatic drain();
        bit save;
        save = rnd_ready;
        rnd_ready = 0;
        repeat (12) @(negedge clk);
        rnd_ready = save;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [23:0] v, b, e;
        int len;
        bit quiet;
        void'($urandom(1234));
        sb_set(0, 2);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk(!play_active && !mem_req && !smp_valid, "R1 outputs", {play_active, mem_req, smp_valid}, 0);
        rd(2'd0, v); chk(v == 0, "R1 ctrl", v, 0);
        rd(2'd3, v); chk(v == 0, "R1 cur", v, 0);

        // R2 encoding
        wr(2'd1, 24'h000100); wr(2'd2, 24'h000100);
        wr(2'd0, 24'h000002); rd(2'd0, v); chk(v == 0, "R2 code 10", v, 0);
        wr(2'd0, 24'h000003); rd(2'd0, v); chk(v == 3, "R2 code 11", v, 3);
        wr(2'd0, 24'h000001); rd(2'd0, v); chk(v == 1, "R2 code 01", v, 1);

        // R11 empty frame (start == end, control already nonzero)
        quiet = 1;
        repeat (20) begin
            @(negedge clk);
            if (play_active || mem_req) quiet = 0;
        end
        chk(quiet, "R11 no fetch", quiet, 1);
        wr(2'd0, 24'h0);

        // R10 bit 0 cleared
        wr(2'd1, 24'h123457); rd(2'd1, v); chk(v == 24'h123456, "R10 start", v, 24'h123456);
        wr(2'd2, 24'h12346F); rd(2'd2, v); chk(v == 24'h12346E, "R10 end", v, 24'h12346E);

        // R3 R6 directed play-once frame of 8 words
        b = 24'h101024; e = 24'h101034;
        wr(2'd1, b); wr(2'd2, e); sb_set(b, e);
        wr(2'd0, 24'h1);
        @(negedge clk);
        chk(play_active == 1'b1, "R3 start", play_active, 1);
        chk(mem_req == 1'b0 && mem_addr == b, "R3 first addr", mem_addr, b);
        for (int i = 0; i < 3000; i++) begin
            rd(2'd0, v);
            if (v == 0) break;
            rd(2'd3, v);
            chk(v[0] == 0 && v >= b && v <= e, "R5 cur", v, b);
        end
        drain();
        chk(wcnt == 8, "R6 count", wcnt, 8);
        chk(!play_active, "R6 active", play_active, 0);
        rd(2'd3, v); chk(v == e, "R6 cur at end", v, e);

        // R6 R5 random play-once frames with back-pressure
        rnd_ready = 1;
        for (int k = 0; k < 6; k++) begin
            len = 1 + ($urandom % 24);
            b = ($urandom & 24'hFFFFFE);
            e = b + 24'(2 * len);
            wr(2'd1, b); wr(2'd2, e); sb_set(b, e);
            wr(2'd0, 24'h1);
            for (int i = 0; i < 3000; i++) begin
                rd(2'd0, v);
                if (v == 0) break;
            end
            drain();
            chk(wcnt == len, "R6 random count", wcnt, len);
            rd(2'd3, v); chk(v == e, "R6 random cur", v, e);
        end

        // R7 loop mode, 4-word frame
        b = 24'h3A0010; e = 24'h3A0018;
        wr(2'd1, b); wr(2'd2, e); sb_set(b, e);
        loop_mon = 1;
        wr(2'd0, 24'h3);
        for (int i = 0; i < 5000 && wcnt < 30; i++) @(negedge clk);
        chk(wcnt >= 30, "R7 progress", wcnt, 30);
        loop_mon = 0;

        // R9 stop
        wr(2'd0, 24'h0);
        @(negedge clk);
        chk(!play_active && !mem_req, "R9 stop", {play_active, mem_req}, 0);
        quiet = 1;
        repeat (20) begin
            @(negedge clk);
            if (mem_req || play_active) quiet = 0;
        end
        chk(quiet, "R9 stays stopped", quiet, 1);

        // R8 chaining: queue a short frame while a long one loops
        b = 24'h002000; e = 24'h002020;
        wr(2'd1, b); wr(2'd2, e); sb_set(b, e);
        loop_mon = 1;
        wr(2'd0, 24'h3);
        for (int i = 0; i < 2000 && wcnt < 2; i++) @(negedge clk);
        wr(2'd1, 24'h008000); wr(2'd2, 24'h00800C);
        nb = 24'h008000; ne = 24'h00800C;
        rd(2'd1, v); chk(v == 24'h008000, "R10 held start", v, 24'h008000);
        rd(2'd3, v); chk(v >= b && v <= e, "R8 still in first frame", v, b);
        for (int i = 0; i < 5000 && wcnt < 40; i++) @(negedge clk);
        chk(wcnt >= 40, "R8 progress", wcnt, 40);
        loop_mon = 0;
        wr(2'd0, 24'h0);
        drain();
        rd(2'd0, v); chk(v == 0, "R9 ctrl off", v, 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule